// File: doc/BRIEF.md
# Prioritized UART Interrupt Status Encoder

This block collects the interrupt requests of one UART channel and turns them into a status byte that software can read, plus a single active-high interrupt output. There are seven request sources: line status error, receive timeout, receive data ready, transmit holding empty, modem status change, Xoff/special character match and CTS/RTS change. Each request is latched as a one-cycle pulse. It stays pending until its own service event clears it. A read shows only the highest-priority source that is both pending and enabled.

The surrounding receiver, transmitter, FIFOs, flow-control engine and comparators are not part of this block. They drive the request pulses and the service strobes. Software controls the per-source enable mask, the extended-feature enable bit and the FIFO-mode bit. The returned byte is captured on the cycle of the read strobe, so it does not change if a new request arrives while the read is in progress.

Top module: `uart_irq_status`

## Requirements
- R1: Priority among visible sources, highest first: line error (req index 0), receive timeout (1), receive data ready (2), transmit empty (3), modem (4), Xoff match (5), CTS/RTS change (6). Only the highest one is encoded.
- R2: Bits 5:0 of the status byte are 000110 for line error, 001100 for receive timeout, 000100 for receive data ready, 000010 for transmit empty, 000000 for modem, 010000 for Xoff match, 100000 for CTS/RTS change, and 000001 when no source is visible.
- R3: Receive timeout and receive data ready share one level and differ only in bit 3; timeout is shown when both are pending. One `ack_rx` clears both.
- R4: Bit 0 is active low: 0 means a source is visible and 1 means none is. After reset the status byte reads 0x01. `irq` is high exactly when at least one source is visible.
- R5: Xoff match and CTS/RTS change are visible, and drive `irq` and bits 5:4, only while `ext_en` is 1.
- R6: A latched Xoff match stays pending through reads and through other service strobes. Only `xon_seen` clears it.
- R7: Bits 7:6 both equal `fifo_en` as sampled at the read. Both bits are 0 after reset.
- R8: Each request pulse latches its source, and the source stays pending until its service strobe. If a request and its clear arrive in the same cycle, the request wins. A lower source is reported by the next read once the higher one has been serviced.
- R9: Transmit empty is cleared by `thr_write`, or by a read that reports transmit empty. A read that reports any other code leaves it pending.
- R10: `irq_mask[i]` gates the visibility of source i. A masked source stays latched and becomes visible as soon as it is unmasked.
- R11: The status byte is captured on the clock edge where `rd_stb` is high. It appears on `rd_data` in the next cycle and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_set | input | 7 | One-cycle request pulses, indexed as in R1 |
| irq_mask | input | 7 | Per-source enable, same indexing |
| ext_en | input | 1 | Extended-feature enable for sources 5 and 6 |
| fifo_en | input | 1 | FIFO mode indicator for bits 7:6 |
| ack_line | input | 1 | Clears line error |
| ack_rx | input | 1 | Clears receive timeout and receive data ready |
| ack_modem | input | 1 | Clears modem change |
| ack_flow | input | 1 | Clears CTS/RTS change |
| xon_seen | input | 1 | Clears Xoff match |
| thr_write | input | 1 | Transmit holding write; clears transmit empty |
| rd_stb | input | 1 | Status register read strobe |
| rd_data | output | 8 | Captured status byte |
| irq | output | 1 | Interrupt output, active high |

## Verification
The bench sweeps all 128 pending patterns against three masks, both settings of the extended enable and both settings of the FIFO bit. Each read is compared with an arithmetic priority model, so a design that ranked data-ready above timeout, or let Xoff leak past a cleared `ext_en`, returns the wrong code. Directed sequences cover four cases: a read that hides transmit empty behind a line error and must not clear it, an Xoff match that has to survive reads and unrelated strobes, a set and a clear arriving in the same cycle, and a request arriving just after a read, which must not disturb the captured byte. A design that cleared transmit empty on any read, or updated `rd_data` continuously, fails these sequences.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int NSRC   = 7;
    localparam int CODE_W = 6;
    localparam int DATA_W = 8;

    localparam int S_LINE  = 0;
    localparam int S_RXTO  = 1;
    localparam int S_RXRDY = 2;
    localparam int S_TXE   = 3;
    localparam int S_MODEM = 4;
    localparam int S_XOFF  = 5;
    localparam int S_FLOW  = 6;

    localparam logic [CODE_W-1:0] CODE_NONE  = 6'b000001;
    localparam logic [CODE_W-1:0] CODE_LINE  = 6'b000110;
    localparam logic [CODE_W-1:0] CODE_RXTO  = 6'b001100;
    localparam logic [CODE_W-1:0] CODE_RXRDY = 6'b000100;
    localparam logic [CODE_W-1:0] CODE_TXE   = 6'b000010;
    localparam logic [CODE_W-1:0] CODE_MODEM = 6'b000000;
    localparam logic [CODE_W-1:0] CODE_XOFF  = 6'b010000;
    localparam logic [CODE_W-1:0] CODE_FLOW  = 6'b100000;

    // sources that need the extended-feature enable
    localparam logic [NSRC-1:0] EXT_SRCS = (NSRC'(1) << S_XOFF) | (NSRC'(1) << S_FLOW);

    function automatic logic [CODE_W-1:0] src_code(input int idx);
        case (idx)
            S_LINE:  src_code = CODE_LINE;
            S_RXTO:  src_code = CODE_RXTO;
            S_RXRDY: src_code = CODE_RXRDY;
            S_TXE:   src_code = CODE_TXE;
            S_MODEM: src_code = CODE_MODEM;
            S_XOFF:  src_code = CODE_XOFF;
            S_FLOW:  src_code = CODE_FLOW;
            default: src_code = CODE_NONE;
        endcase
    endfunction

    typedef struct packed {
        logic [DATA_W-1:0] rd_data;
    } stat_state_t;
endpackage

// File: rtl/uart_irq_src_latch.sv
module uart_irq_src_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    logic pend_d, pend_q;

    // a new request outranks a clear in the same cycle
    always_comb begin
        pend_d = set_i | (pend_q & ~clr_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/uart_irq_prio_enc.sv
module uart_irq_prio_enc
    import uart_irq_pkg::*;
(
    input  logic [NSRC-1:0]   visible_i,
    output logic [CODE_W-1:0] code_o,
    output logic              any_o
);
    // walk from lowest to highest priority so the highest overrides
    always_comb begin
        code_o = CODE_NONE;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (visible_i[i]) code_o = src_code(i);
        end
        any_o = |visible_i;
    end
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   req_set,
    input  logic [NSRC-1:0]   irq_mask,
    input  logic              ext_en,
    input  logic              fifo_en,
    input  logic              ack_line,
    input  logic              ack_rx,
    input  logic              ack_modem,
    input  logic              ack_flow,
    input  logic              xon_seen,
    input  logic              thr_write,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    localparam logic [DATA_W-1:0] RST_DATA = {{(DATA_W-CODE_W){1'b0}}, CODE_NONE};

    logic [NSRC-1:0]   pend_q;
    logic [NSRC-1:0]   clr;
    logic [NSRC-1:0]   ext_gate;
    logic [NSRC-1:0]   visible;
    logic [CODE_W-1:0] code;
    logic              any_vis;
    stat_state_t       st_d, st_q;

    assign ext_gate = ext_en ? {NSRC{1'b1}} : ~EXT_SRCS;
    assign visible  = pend_q & irq_mask & ext_gate;

    uart_irq_prio_enc enc_i (
        .visible_i (visible),
        .code_o    (code),
        .any_o     (any_vis)
    );

    always_comb begin
        clr          = '0;
        clr[S_LINE]  = ack_line;
        clr[S_RXTO]  = ack_rx;
        clr[S_RXRDY] = ack_rx;
        clr[S_TXE]   = thr_write | (rd_stb & (code == CODE_TXE) & any_vis);
        clr[S_MODEM] = ack_modem;
        clr[S_XOFF]  = xon_seen;
        clr[S_FLOW]  = ack_flow;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        uart_irq_src_latch lat_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (req_set[g]),
            .clr_i  (clr[g]),
            .pend_o (pend_q[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (rd_stb) st_d.rd_data = {{(DATA_W-CODE_W){fifo_en}}, code};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.rd_data <= RST_DATA;
        else        st_q         <= st_d;
    end

    assign rd_data = st_q.rd_data;
    assign irq     = any_vis;
endmodule

// File: rtl/uart_irq_status_chk.sv
module uart_irq_status_chk
    import uart_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rd_stb,
    input logic [DATA_W-1:0] rd_data,
    input logic              irq,
    input logic [NSRC-1:0]   irq_mask,
    input logic [NSRC-1:0]   pend,
    input logic              ext_en,
    input logic              fifo_en,
    input logic              xon_seen
);
    a_r4_bit0_tracks_irq: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_data[0] == !$past(irq));

    a_r7_fifo_bits: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_data[7:6] == {2{$past(fifo_en)}});

    a_r5_ext_bits_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !ext_en) |=> rd_data[5:4] == 2'b00);

    a_r5_ext_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_en && ((pend & irq_mask & ~EXT_SRCS) == '0)) |-> !irq);

    a_r10_mask_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask == '0) |-> !irq);

    a_r6_xoff_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[S_XOFF] && !xon_seen) |=> pend[S_XOFF]);

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));
endmodule

bind uart_irq_status uart_irq_status_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_stb   (rd_stb),
    .rd_data  (rd_data),
    .irq      (irq),
    .irq_mask (irq_mask),
    .pend     (pend_q),
    .ext_en   (ext_en),
    .fifo_en  (fifo_en),
    .xon_seen (xon_seen)
);

// File: tb/uart_irq_status_tb_top.sv
module uart_irq_status_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] req_set = '0, irq_mask = '1;
    logic       ext_en = 1'b1, fifo_en = 1'b0;
    logic       ack_line = 0, ack_rx = 0, ack_modem = 0, ack_flow = 0;
    logic       xon_seen = 0, thr_write = 0, rd_stb = 0;
    logic [7:0] rd_data;
    logic       irq;
    int         checks = 0, errors = 0;
    bit         done = 0;

    always #5 clk = ~clk;

    uart_irq_status dut_i (
        .clk(clk), .rst_n(rst_n), .req_set(req_set), .irq_mask(irq_mask),
        .ext_en(ext_en), .fifo_en(fifo_en), .ack_line(ack_line), .ack_rx(ack_rx),
        .ack_modem(ack_modem), .ack_flow(ack_flow), .xon_seen(xon_seen),
        .thr_write(thr_write), .rd_stb(rd_stb), .rd_data(rd_data), .irq(irq)
    );

    function automatic logic [6:0] vis(input logic [6:0] p, input logic [6:0] m, input logic e);
        return p & m & (e ? 7'h7f : 7'h1f);
    endfunction

    function automatic logic [5:0] exp_code(input logic [6:0] v);
        if (v[0])      return 6'b000110;
        else if (v[1]) return 6'b001100;
        else if (v[2]) return 6'b000100;
        else if (v[3]) return 6'b000010;
        else if (v[4]) return 6'b000000;
        else if (v[5]) return 6'b010000;
        else if (v[6]) return 6'b100000;
        return 6'b000001;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic pulse_req(input logic [6:0] p);
        req_set = p; @(negedge clk); req_set = '0;
    endtask

    task automatic do_read();
        rd_stb = 1'b1; @(negedge clk); rd_stb = 1'b0;
    endtask

    task automatic clear_all();
        ack_line = 1; ack_rx = 1; ack_modem = 1; ack_flow = 1; xon_seen = 1; thr_write = 1;
        @(negedge clk);
        ack_line = 0; ack_rx = 0; ack_modem = 0; ack_flow = 0; xon_seen = 0; thr_write = 0;
    endtask

    task automatic expect_read(input logic [7:0] exp, input string tag);
        do_read();
        check(rd_data == exp, tag, rd_data, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=00 expected=01");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [6:0] masks [3];
        masks[0] = 7'h7f; masks[1] = 7'h2a; masks[2] = 7'h55;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4 R7 reset state
        check(rd_data == 8'h01, "R4 R7 reset byte", rd_data, 8'h01);
        check(irq == 1'b0, "R4 reset irq", {7'b0, irq}, 8'h00);

        // R1 R2 R3 R4 R5 R7 R10 sweep
        for (int p = 0; p < 128; p++) begin
            for (int e = 0; e < 2; e++) begin
                for (int mi = 0; mi < 3; mi++) begin
                    logic [6:0] v;
                    logic [7:0] ex;
                    logic       f;
                    clear_all();
                    irq_mask = masks[mi]; ext_en = e[0]; f = p[0] ^ mi[0];
                    fifo_en = f;
                    pulse_req(p[6:0]);
                    v = vis(p[6:0], masks[mi], e[0]);
                    check(irq == (v != 0), "R4 R5 R10 irq sweep", {7'b0, irq}, {7'b0, v != 0});
                    ex = {f, f, exp_code(v)};
                    expect_read(ex, "R1 R2 R3 R5 R7 R10 sweep");
                end
            end
        end
        clear_all();
        irq_mask = 7'h7f; ext_en = 1; fifo_en = 0;

        // R9: read reporting tx clears it
        pulse_req(7'b0001000);
        expect_read(8'h02, "R9 tx shown");
        expect_read(8'h01, "R9 tx cleared by read");
        // R9 R8: hidden tx survives a read, then shows
        pulse_req(7'b0001001);
        expect_read(8'h06, "R8 line first");
        ack_line = 1; @(negedge clk); ack_line = 0;
        expect_read(8'h02, "R9 tx survives other read");
        // R9: thr_write clears
        pulse_req(7'b0001000);
        thr_write = 1; @(negedge clk); thr_write = 0;
        expect_read(8'h01, "R9 thr_write clears");

        // R3: ack_rx clears both
        pulse_req(7'b0000110);
        expect_read(8'h0c, "R3 timeout over ready");
        ack_rx = 1; @(negedge clk); ack_rx = 0;
        expect_read(8'h01, "R3 ack_rx clears both");

        // R6: xoff sticky
        pulse_req(7'b0100000);
        ack_flow = 1; ack_line = 1; ack_rx = 1; ack_modem = 1; thr_write = 1;
        @(negedge clk);
        ack_flow = 0; ack_line = 0; ack_rx = 0; ack_modem = 0; thr_write = 0;
        expect_read(8'h10, "R6 xoff after other strobes");
        expect_read(8'h10, "R6 xoff after read");
        // R5: gating off hides but keeps it
        ext_en = 0; @(negedge clk);
        check(irq == 0, "R5 xoff hidden irq", {7'b0, irq}, 8'h00);
        expect_read(8'h01, "R5 xoff hidden byte");
        ext_en = 1;
        expect_read(8'h10, "R6 xoff back after enable");
        xon_seen = 1; @(negedge clk); xon_seen = 0;
        expect_read(8'h01, "R6 xon clears");

        // R10: masked stays latched
        irq_mask = 7'h6f;
        pulse_req(7'b0010000);
        check(irq == 0, "R10 masked irq", {7'b0, irq}, 8'h00);
        irq_mask = 7'h7f; @(negedge clk);
        check(irq == 1, "R10 unmasked irq", {7'b0, irq}, 8'h01);
        expect_read(8'h00, "R10 modem visible after unmask");
        clear_all();

        // R8: set wins over simultaneous clear
        req_set = 7'b0000001; ack_line = 1; @(negedge clk);
        req_set = '0; ack_line = 0;
        expect_read(8'h06, "R8 set beats clear");
        clear_all();

        // R11: capture and hold
        fifo_en = 1;
        pulse_req(7'b0010000);
        do_read();
        pulse_req(7'b0000001);
        @(negedge clk);
        check(rd_data == 8'hc0, "R11 hold after new request", rd_data, 8'hc0);
        expect_read(8'hc6, "R11 next read updates");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule